// File: doc/BRIEF.md
# Expansion Interrupt Collector

This block gathers a set of external interrupt sources into a secondary interrupt controller that is accessed through memory-mapped registers. A synchroniser and an edge detector process each source line. A rising edge on a line latches a pending bit. The pending bits that are also enabled are combined into one active-high level output, and that output feeds one input of a parent interrupt controller.

Software controls the enable mask only through two write-one registers. One register sets enable bits and the other clears them, so a driver never needs a read-modify-write sequence to change one line. A pending bit is acknowledged by writing a one to its position in the status register. To bring the block to a quiet state, software writes all ones to the clear register and then all ones to the status register. A handler reads the status register, combines it with the mask, and services each set bit.

Top module: `irqx_expander`

## Requirements
- R1: After reset the enable mask and all pending bits are zero, `irq_o` is low and `rd_data_o` is zero.
- R2: A write to address 0 (enable-set) sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to address 1 (enable-clear) clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Address 0 and address 1 both read back the current mask, where 1 means enabled. Address 2 reads the pending bits and address 3 reads zero. `rd_data_o` is loaded on the clock edge that samples `rd_en_i` and holds its value while `rd_en_i` is low.
- R5: Bit i of the pending register is set when line i has a rising edge. A change on `src_i` appears in the pending register at the third clock edge after the change. A line that stays high sets its pending bit only once.
- R6: A write to address 2 (status) clears each pending bit whose write-data bit is 1. A write-data bit of 0 has no effect on its pending bit.
- R7: When a rising edge and a write-one clear reach the same pending bit in the same cycle, the bit is set.
- R8: `irq_o` is high exactly when some bit is both pending and enabled. It follows a change of the mask or of the pending bits one clock later.
- R9: Software can quiet the block by writing all ones to enable-clear and then all ones to status. After that sequence no line is enabled or pending and `irq_o` is low.
- R10: Only writes to addresses 0 and 1 change the mask. Only writes to address 2 can clear a pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 2 | Register address: 0 enable-set, 1 enable-clear, 2 status |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wr_data_i | input | 16 | Write data, one bit per line |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |
| src_i | input | 16 | Raw asynchronous interrupt sources |
| irq_o | output | 1 | Level-high interrupt to the parent controller |

## Verification
The bench drives a write-one clear into the exact cycle in which a rising edge reaches the pending register. A design that let the clear win would lose that interrupt. It also holds a source high after acknowledging it, which catches a design that treats the source as a level and fires again. Zero bits in set, clear and status writes are mixed with random data, so a design that overwrites the mask or status instead of merging into it returns the wrong readback. Exact-cycle checks on `irq_o` after a mask write, and on the pending bit after a source edge, expose a design that drops or adds a register stage.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_EN_SET = 2'd0,
    A_EN_CLR = 2'd1,
    A_STATUS = 2'd2,
    A_SPARE  = 2'd3
  } irqx_addr_e;
endpackage

// File: rtl/irqx_rst_sync.sv
module irqx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqx_status.sv
module irqx_status #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] level_i,
  input  logic             ack_en_i,
  input  logic [LINES-1:0] ack_bits_i,
  output logic [LINES-1:0] pend_o,
  output logic [LINES-1:0] rise_o
);
  logic [LINES-1:0] last_q;
  logic [LINES-1:0] pend_q, pend_d;
  logic [LINES-1:0] ack_mask;

  // Per-line edge detect and pending update; a new edge outranks an ack.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign rise_o[g]   = level_i[g] & ~last_q[g];
    assign ack_mask[g] = ack_en_i & ack_bits_i[g];
    assign pend_d[g]   = rise_o[g] | (pend_q[g] & ~ack_mask[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      pend_q <= '0;
    end else begin
      last_q <= level_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqx_mask.sv
module irqx_mask #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [LINES-1:0] bits_i,
  output logic [LINES-1:0] mask_o
);
  logic [LINES-1:0] mask_q, mask_d;
  logic             mask_ce;

  assign mask_ce = set_en_i | clr_en_i;

  always_comb begin
    mask_d = mask_q;
    if (set_en_i)      mask_d = mask_q | bits_i;
    else if (clr_en_i) mask_d = mask_q & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irqx_regif.sv
module irqx_regif
  import irqx_pkg::*;
#(
  parameter int unsigned LINES = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [LINES-1:0]      mask_i,
  input  logic [LINES-1:0]      pend_i,
  output logic                  set_en_o,
  output logic                  clr_en_o,
  output logic                  ack_en_o,
  output logic [LINES-1:0]      rd_data_o
);
  irqx_addr_e       sel;
  logic [LINES-1:0] rd_d, rd_q;

  assign sel      = irqx_addr_e'(addr_i);
  assign set_en_o = wr_en_i && (sel == A_EN_SET);
  assign clr_en_o = wr_en_i && (sel == A_EN_CLR);
  assign ack_en_o = wr_en_i && (sel == A_STATUS);

  always_comb begin
    unique case (sel)
      A_EN_SET, A_EN_CLR: rd_d = mask_i;
      A_STATUS:           rd_d = pend_i;
      default:            rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/irqx_expander.sv
module irqx_expander
  import irqx_pkg::*;
#(
  parameter int unsigned LINES       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic [LINES-1:0]      wr_data_i,
  input  logic                  rd_en_i,
  output logic [LINES-1:0]      rd_data_o,
  input  logic [LINES-1:0]      src_i,
  output logic                  irq_o
);
  logic             rst_n;
  logic [LINES-1:0] src_sync;
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] mask_q;
  logic             set_en, clr_en, ack_en;
  logic             irq_q, irq_d;

  irqx_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  irqx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .async_i(src_i), .sync_o(src_sync)
  );

  irqx_status #(.LINES(LINES)) u_status (
    .clk_i(clk_i), .rst_ni(rst_n), .level_i(src_sync),
    .ack_en_i(ack_en), .ack_bits_i(wr_data_i),
    .pend_o(pend_q), .rise_o(rise)
  );

  irqx_mask #(.LINES(LINES)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_n), .set_en_i(set_en), .clr_en_i(clr_en),
    .bits_i(wr_data_i), .mask_o(mask_q)
  );

  irqx_regif #(.LINES(LINES)) u_regif (
    .clk_i(clk_i), .rst_ni(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .mask_i(mask_q), .pend_i(pend_q),
    .set_en_o(set_en), .clr_en_o(clr_en), .ack_en_o(ack_en),
    .rd_data_o(rd_data_o)
  );

  assign irq_d = |(pend_q & mask_q);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
  parameter int unsigned LINES = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [1:0]       addr_i,
  input logic             wr_en_i,
  input logic [LINES-1:0] wr_data_i,
  input logic [LINES-1:0] mask_q,
  input logic [LINES-1:0] pend_q,
  input logic [LINES-1:0] rise,
  input logic             irq_o
);
  p_mask_set_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd0) |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

  p_mask_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd1) |=> ((mask_q & $past(wr_data_i)) == '0));

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(pend_q & mask_q))));

  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en_i && (addr_i == 2'd0 || addr_i == 2'd1)) |=> $stable(mask_q));

  p_pend_no_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en_i && addr_i == 2'd2) |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

bind irqx_expander irqx_checker #(.LINES(LINES)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .mask_q(mask_q), .pend_q(pend_q), .rise(rise),
  .irq_o(irq_o)
);

// File: tb/test_irqx_expander.sv
module test_irqx_expander;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr_en, rd_en;
  logic [15:0] wr_data, rd_data, src;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_mask, m_pend, m_src;

  always #2 clk = ~clk;

  irqx_expander i_irqx_expander (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .src_i(src), .irq_o(irq)
  );

  function automatic logic exp_irq(input logic [15:0] p, input logic [15:0] m);
    return |(p & m);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    if (a == 2'd0) m_mask = m_mask | d;
    else if (a == 2'd1) m_mask = m_mask & ~d;
    else if (a == 2'd2) m_pend = m_pend & ~d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_src(input logic [15:0] v);
    @(negedge clk); src = v;
    m_pend = m_pend | (v & ~m_src);
    m_src = v;
    settle(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd1234));
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; src = '0;
    m_mask = '0; m_pend = '0; m_src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle(4);

    // R1 reset state
    check("R1 rd_data", rd_data, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);
    rd(2'd0, r); check("R1 mask", r, 16'h0);
    rd(2'd2, r); check("R1 pend", r, 16'h0);

    // R2 / R3 / R4 directed merges
    wr(2'd0, 16'h00F0); wr(2'd0, 16'h0300);
    rd(2'd0, r); check("R2 set merge", r, 16'h03F0);
    wr(2'd1, 16'h0110);
    rd(2'd1, r); check("R3 clr merge via addr1 R4", r, 16'h02E0);
    rd(2'd3, r); check("R4 spare reads zero", r, 16'h0);
    @(negedge clk); addr = 2'd2;
    settle(2);
    check("R4 hold without rd_en", rd_data, 16'h0);

    // R5 exact latency: visible at third edge
    @(negedge clk); src = 16'h0020;
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 2'd2; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
    check("R5 not yet pending at 2nd edge", rd_data, 16'h0);
    rd(2'd2, r); check("R5 pending at 3rd edge", r, 16'h0020);
    m_src = 16'h0020; m_pend = 16'h0020;
    // R8: bit5 enabled (mask 02E0), irq registered
    settle(1);
    check("R8 irq on enabled pend", {15'b0, irq}, 16'h1);
    // R6: zero bits no effect, one clears; R5 held level no refire
    wr(2'd2, 16'hFFDF);
    rd(2'd2, r); check("R6 zero bits keep", r, 16'h0020);
    wr(2'd2, 16'h0020);
    settle(6);
    rd(2'd2, r); check("R5 held high no refire", r, 16'h0);
    check("R8 irq low after ack", {15'b0, irq}, 16'h0);

    // R8 exact latency after mask change
    drive_src(16'h0021);
    wr(2'd1, 16'hFFFF);
    settle(1);
    check("R8 masked irq low", {15'b0, irq}, 16'h0);
    wr(2'd0, 16'h0001);
    check("R8 irq not yet", {15'b0, irq}, 16'h0);
    settle(1);
    check("R8 irq one cycle later", {15'b0, irq}, 16'h1);

    // R7: edge and ack in same cycle
    @(negedge clk); src = 16'h0023;
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 2'd2; wr_data = 16'h0002; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    m_src = 16'h0023; m_pend = m_pend | 16'h0002;
    rd(2'd2, r); check("R7 set beats clear", r, m_pend);

    // R9 init sequence
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF);
    settle(1);
    rd(2'd0, r); check("R9 mask zero", r, 16'h0);
    rd(2'd2, r); check("R9 pend zero", r, 16'h0);
    check("R9 irq low", {15'b0, irq}, 16'h0);

    // Random mix (R2 R3 R4 R5 R6 R8 R10)
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [15:0] d;
      op = int'($urandom_range(0, 4));
      d = 16'($urandom);
      case (op)
        0: wr(2'd0, d);
        1: wr(2'd1, d);
        2: wr(2'd2, d);
        3: drive_src(d & 16'($urandom));
        default: begin
          @(negedge clk); addr = 2'd3; wr_data = d; wr_en = 1'b1;
          @(posedge clk);
          @(negedge clk); wr_en = 1'b0;
        end
      endcase
      settle(1);
      check("R8 random irq", {15'b0, irq}, {15'b0, exp_irq(m_pend, m_mask)});
      rd(2'($urandom_range(0, 3)), r);
      case (addr)
        2'd0, 2'd1: check("R10 random mask readback R2 R3", r, m_mask);
        2'd2:       check("R10 random pend readback R5 R6", r, m_pend);
        default:    check("R4 random spare", r, 16'h0);
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule